// File: doc/BRIEF.md
# Writeback Data-Rate Pattern Sequencer

This block paces a block of write data words onto a system bus. A 4-bit rate code selects one of nine repeating patterns of data cycles (D) and idle cycles (x). The sequencer pulls words from an upstream source over a ready/valid handshake, and only in the data cycles of the pattern. It drives each accepted word onto the bus one cycle later, with a valid strobe. When the last word of the block has gone out, it raises a one-cycle done pulse.

The word width is a parameter. A 64-bit bus and a 32-bit bus run the same patterns; only the word width differs. The rate code is captured when a transfer starts. A reserved code falls back to the every-cycle pattern and raises an error flag. If the source has no word ready in a data cycle, the pattern waits at that position until a word arrives.

Top module: `wbr_seq`

## Requirements
- R1: Rate code 0 gives a data cycle at every position. With the source always valid, the four words of a block leave on four consecutive cycles.
- R2: A word is accepted on a clock edge where `src_valid` and `src_ready` are both high. It appears on `wr_data`, with `wr_valid` high, in the cycle after that edge. `wr_valid` is high at no other time.
- R3: Codes 1 to 8 repeat the following patterns, written with the first position on the left. Code 1 is DDx, code 2 is DDxx, code 3 is DxDx and code 4 is DDxxx. Code 5 is DDxxxx, code 6 is DxxDxx, code 7 is DDxxxxxx and code 8 is DxxxDxxx. `src_ready` is high only during a D position of a running transfer.
- R4: If `src_valid` is low in a D position, the pattern holds at that position and `src_ready` stays high until a word is accepted.
- R5: A transfer issues exactly `WORDS` words (default 4). `done` pulses together with the `wr_valid` of the last word. From that cycle on, `src_ready` is low until the next start.
- R6: A start is accepted only while no transfer is running, and `rate_code` is sampled only at that moment. Changes to `rate_code`, and start pulses, during a transfer have no effect on its timing.
- R7: Codes 9 to 15 run as code 0 and set `rate_err`. An accepted start with a code from 0 to 8 clears `rate_err`. `rate_err` changes only on an accepted start.
- R8: While `rst` is high and after it is released, `wr_valid`, `done`, `src_ready` and `rate_err` are low.
- R9: Every accepted start begins the pattern at its first position, whatever position the previous transfer ended at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | 4 | Pattern select, sampled at an accepted start |
| start | input | 1 | Begins a transfer when the block is idle |
| src_valid | input | 1 | Source holds a word |
| src_ready | output | 1 | Sequencer takes the word this cycle |
| src_data | input | DATA_W | Word from the source |
| wr_valid | output | 1 | Bus data-cycle strobe |
| wr_data | output | DATA_W | Bus write word |
| done | output | 1 | Last word of the block is on the bus |
| rate_err | output | 1 | The last accepted code was reserved |

## Verification
The assertions check on every cycle that each accepted word appears one cycle later with its data unchanged. They also check that no strobe appears without an accepted word, that a stall holds `src_ready` high, that `done` coincides with a strobe and leaves the handshake closed, and that `rate_err` moves only on an accepted start. The placement of data cycles within each of the nine patterns, the exact number of words per block, the restart at the first position, and the indifference to codes changed in the middle of a transfer can only be shown by the bench. It runs a cycle-accurate model of the patterns against the outputs, and runs directed transfers whose latency it measures against values computed from the pattern strings.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    localparam int CODE_W  = 4;
    localparam int PAT_MAX = 8;
    localparam int POS_W   = $clog2(PAT_MAX);
    localparam int TOP_CODE = 8;

    typedef logic [CODE_W-1:0] rate_code_t;

    // mask bit i set: position i is a data slot; last: final position index
    typedef struct packed {
        logic [PAT_MAX-1:0] mask;
        logic [POS_W-1:0]   last;
    } pat_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_e;

    function automatic logic code_reserved(rate_code_t c);
        return c > rate_code_t'(TOP_CODE);
    endfunction

    function automatic pat_t pat_lookup(rate_code_t c);
        pat_t p;
        case (c)
            4'd1:    p = '{mask: 8'b0000_0011, last: 3'd2};
            4'd2:    p = '{mask: 8'b0000_0011, last: 3'd3};
            4'd3:    p = '{mask: 8'b0000_0101, last: 3'd3};
            4'd4:    p = '{mask: 8'b0000_0011, last: 3'd4};
            4'd5:    p = '{mask: 8'b0000_0011, last: 3'd5};
            4'd6:    p = '{mask: 8'b0000_1001, last: 3'd5};
            4'd7:    p = '{mask: 8'b0000_0011, last: 3'd7};
            4'd8:    p = '{mask: 8'b0001_0001, last: 3'd7};
            default: p = '{mask: 8'b0000_0001, last: 3'd0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/wbr_rate_latch.sv
module wbr_rate_latch
    import wbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  rate_code_t code,
    output pat_t       pat,
    output logic       err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pat <= pat_lookup('0);
            err <= 1'b0;
        end else if (load) begin
            pat <= pat_lookup(code_reserved(code) ? rate_code_t'(0) : code);
            err <= code_reserved(code);
        end
    end
endmodule

// File: rtl/wbr_slot_walker.sv
module wbr_slot_walker
    import wbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic fire,
    input  pat_t pat,
    output logic slot_data
);
    logic [POS_W-1:0] pos;
    logic             advance;

    assign slot_data = pat.mask[pos];
    assign advance   = run && (!slot_data || fire);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos <= '0;
        end else if (advance) begin
            pos <= (pos == pat.last) ? '0 : pos + 1'b1;
        end
    end
endmodule

// File: rtl/wbr_word_count.sv
module wbr_word_count #(
    parameter int WORDS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fire,
    output logic last_word
);
    localparam int CNT_W = $clog2(WORDS + 1);

    logic [CNT_W-1:0] cnt;

    assign last_word = (cnt == CNT_W'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (fire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wbr_seq.sv
module wbr_seq
    import wbr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rate_code,
    input  logic              start,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              rate_err
);
    run_st_e st;
    logic    busy;
    logic    accept;
    logic    fire;
    logic    slot_data;
    logic    last_word;
    pat_t    pat;

    assign busy      = (st == ST_RUN);
    assign accept    = start && !busy;
    assign src_ready = busy && slot_data;
    assign fire      = src_ready && src_valid;

    wbr_rate_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .code (rate_code),
        .pat  (pat),
        .err  (rate_err)
    );

    wbr_slot_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .restart   (accept),
        .run       (busy),
        .fire      (fire),
        .pat       (pat),
        .slot_data (slot_data)
    );

    wbr_word_count #(.WORDS(WORDS)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .fire      (fire),
        .last_word (last_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else if (accept) begin
            st <= ST_RUN;
        end else if (fire && last_word) begin
            st <= ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
            done     <= 1'b0;
        end else begin
            wr_valid <= fire;
            done     <= fire && last_word;
            if (fire) begin
                wr_data <= src_data;
            end
        end
    end
endmodule

// File: rtl/wbr_seq_chk.sv
module wbr_seq_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              src_valid,
    input logic              src_ready,
    input logic [DATA_W-1:0] src_data,
    input logic              wr_valid,
    input logic [DATA_W-1:0] wr_data,
    input logic              done,
    input logic              rate_err
);
    a_r2_fire_gives_strobe: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |=> wr_valid);

    a_r2_strobe_needs_fire: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(src_valid && src_ready));

    a_r2_data_passes: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_data == $past(src_data)));

    a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (src_ready && !src_valid) |=> src_ready);

    a_r5_done_on_strobe: assert property (@(posedge clk) disable iff (rst)
        done |-> wr_valid);

    a_r5_done_closes: assert property (@(posedge clk) disable iff (rst)
        done |-> !src_ready);

    a_r7_err_only_on_start: assert property (@(posedge clk) disable iff (rst)
        !(start && !busy) |=> $stable(rate_err));
endmodule

bind wbr_seq wbr_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .done      (done),
    .rate_err  (rate_err)
);

// File: tb/sim_wbr_seq.sv
module sim_wbr_seq;
    localparam int DW = 64;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    rate_code = '0;
    logic          start = 1'b0;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [DW-1:0] src_data = '0;
    logic          wr_valid;
    logic [DW-1:0] wr_data;
    logic          done;
    logic          rate_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    wbr_seq #(.DATA_W(DW), .WORDS(NW)) u0 (
        .clk(clk), .rst(rst), .rate_code(rate_code), .start(start),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .wr_valid(wr_valid), .wr_data(wr_data), .done(done), .rate_err(rate_err)
    );

    function automatic string pat_str(int c);
        case (c)
            1: return "DDx";
            2: return "DDxx";
            3: return "DxDx";
            4: return "DDxxx";
            5: return "DDxxxx";
            6: return "DxxDxx";
            7: return "DDxxxxxx";
            8: return "DxxxDxxx";
            default: return "D";
        endcase
    endfunction

    function automatic bit pat_bit(int c, int p);
        string s = pat_str(c);
        return s[p] == "D";
    endfunction

    // steps from the start step until done is seen, with the source always valid
    function automatic int exp_lat(int c);
        string s = pat_str(c);
        int    mc = (c > 8) ? 0 : c;
        int    got = 0;
        s = pat_str(mc);
        for (int i = 0; i < 64; i++) begin
            if (s[i % s.len()] == "D") begin
                got++;
                if (got == NW) return i + 2;
            end
        end
        return -1;
    endfunction

    // reference model
    bit          m_busy = 0;
    int          m_pos = 0, m_cnt = 0, m_code = 0;
    bit          e_valid = 0, e_done = 0, e_err = 0;
    logic [DW-1:0] e_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_pos = 0; m_cnt = 0; m_code = 0;
            e_valid = 0; e_done = 0; e_err = 0;
        end else begin
            bit rdy;
            bit fr;
            rdy = m_busy && pat_bit(m_code, m_pos);
            fr = rdy && src_valid;
            e_valid = fr;
            e_done = 0;
            if (fr) e_data = src_data;
            if (m_busy) begin
                if (!rdy || fr)
                    m_pos = (m_pos == pat_str(m_code).len() - 1) ? 0 : m_pos + 1;
                if (fr) begin
                    if (m_cnt == NW - 1) begin
                        e_done = 1;
                        m_busy = 0;
                    end
                    m_cnt++;
                end
            end else if (start) begin
                m_busy = 1; m_pos = 0; m_cnt = 0;
                if (rate_code > 8) begin m_code = 0; e_err = 1; end
                else begin m_code = int'(rate_code); e_err = 0; end
            end
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit er = m_busy && pat_bit(m_code, m_pos);
        check(src_ready == er, "R3", "src_ready", longint'(src_ready), longint'(er));
        check(wr_valid == e_valid, "R2", "wr_valid", longint'(wr_valid), longint'(e_valid));
        if (e_valid)
            check(wr_data == e_data, "R2", "wr_data", longint'(wr_data), longint'(e_data));
        check(done == e_done, "R5", "done", longint'(done), longint'(e_done));
        check(rate_err == e_err, "R7", "rate_err", longint'(rate_err), longint'(e_err));
    endtask

    task automatic step(bit st, int code, int vprob);
        @(negedge clk);
        compare_all();
        start = st;
        rate_code = 4'(code);
        src_valid = ($urandom % 100) < vprob;
        src_data = {$urandom, $urandom};
    endtask

    // start step, then run until done; returns steps taken
    task automatic run_xfer(int code, int vprob, int mid_code, bit mid_start, output int lat);
        step(1, code, vprob);
        lat = 0;
        for (int k = 0; k < 200; k++) begin
            step(mid_start && (k == 1), (k == 0) ? code : mid_code, vprob);
            lat++;
            if (done) break;
        end
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        int lat2;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(!wr_valid && !done && !src_ready && !rate_err, "R8", "outputs in reset",
              longint'({wr_valid, done, src_ready, rate_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!wr_valid && !done && !src_ready && !rate_err, "R8", "outputs after reset",
              longint'({wr_valid, done, src_ready, rate_err}), 0);

        // R1: code 0 back to back
        run_xfer(0, 100, 0, 0, lat);
        check(lat == exp_lat(0), "R1", "code 0 latency", lat, exp_lat(0));

        // R3: every defined pattern with a full source
        for (int c = 1; c <= 8; c++) begin
            run_xfer(c, 100, c, 0, lat);
            check(lat == exp_lat(c), "R3", $sformatf("code %0d latency", c), lat, exp_lat(c));
        end

        // R6: code changed and start pulsed mid-transfer
        run_xfer(8, 100, 0, 1, lat);
        check(lat == exp_lat(8), "R6", "mid-transfer code/start ignored", lat, exp_lat(8));

        // R9: same code twice, each restarts at position 0
        run_xfer(1, 100, 1, 0, lat);
        run_xfer(1, 100, 1, 0, lat2);
        check(lat2 == lat && lat == exp_lat(1), "R9", "restart latency", lat2, exp_lat(1));

        // R7: reserved code behaves as code 0 and flags, then cleared
        run_xfer(13, 100, 13, 0, lat);
        check(lat == exp_lat(0), "R7", "reserved latency", lat, exp_lat(0));
        check(rate_err == 1'b1, "R7", "flag set", longint'(rate_err), 1);
        run_xfer(2, 100, 2, 0, lat);
        check(rate_err == 1'b0, "R7", "flag cleared", longint'(rate_err), 0);

        // R4: starved source stretches the transfer
        run_xfer(6, 30, 6, 0, lat);
        check(lat >= exp_lat(6), "R4", "stalled latency not shorter", lat, exp_lat(6));

        // random mix; the model checks R2 R3 R4 R5 R6 R7 each cycle
        for (int t = 0; t < 60; t++) begin
            int c = $urandom % 16;
            int vp = 40 + ($urandom % 61);
            run_xfer(c, vp, $urandom % 16, ($urandom % 3) == 0, lat);
            repeat ($urandom % 3) step(0, c, vp);
        end

        repeat (4) step(0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule